// File: doc/BRIEF.md
# SPI Control Write Port

This block receives register writes on a three-wire serial control bus and turns each one into a one-cycle write for an external bank of 8-bit registers. The bus uses an active-low chip select, a serial clock and a serial data line, and all three are inputs. The pins are asynchronous to the system clock, so each pin passes through a synchronizer, and the block finds serial-clock rising edges by comparing the synchronized level with its value on the previous system clock.

The chip-select pin is shared with an address-strap function that another bus mode uses. After reset the port stays in that other mode and ignores serial traffic. The first falling edge seen on the shared pin switches it to serial mode, and it stays in serial mode until the next reset.

Each frame carries three kinds of byte, in order:
- a fixed chip-address byte;
- a pointer byte, which holds an auto-advance flag and a register index;
- any number of data bytes.

When auto-advance is set, each data byte goes to the next register in turn. When it is clear, every data byte goes to the same register.

Top module: `spi_ctl_port`

## Requirements
- R1: After reset, `spi_mode` is 0 and `wr_en` is 0.
- R2: While `spi_mode` is 0, serial traffic has no effect. The first falling edge of `cs_pin` after reset sets `spi_mode` to 1, and it stays 1, even with `cs_pin` high, until the next reset.
- R3: `sdi` is sampled on each rising edge of `sck`, and bytes are assembled most significant bit first.
- R4: The first byte of a frame must be 0x20, which is chip address 0x10 in bits 7:1 with a 0 in bit 0. If it is any other value, no byte of that frame causes a write.
- R5: The second byte is the pointer. Bit 7 is the auto-advance flag and bits 6:0 are the starting register index.
- R6: When auto-advance is 1, data byte k of the frame (counting from 0) is written to index (start + k) mod 128.
- R7: When auto-advance is 0, every data byte of the frame is written to the starting index, so the last byte wins.
- R8: Raising `cs_pin` at any bit position ends the frame and discards any partial byte. The next frame starts again with its address byte.
- R9: A write whose index is NUM_REGS or higher is suppressed: `wr_en` stays low, but the index still advances.
- R10: Each completed data byte that is accepted produces exactly one single-cycle `wr_en` pulse, with `wr_addr` and `wr_data` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_pin | input | 1 | Shared chip-select / address pin, active low in serial mode |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| spi_mode | output | 1 | Latched serial-mode flag |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 7 | Register index for the write |
| wr_data | output | 8 | Byte to write |

## Verification
The bench aims at the index wrap from 127 to 0. A design that drops the modulo, or that suppresses index 0 after the wrap, leaves register 0 unwritten.

It raises chip select in the middle of a byte, both in the address phase and in the data phase. A design that keeps its bit counter across frames misaligns every later byte, and a design that flushes the partial byte writes garbage.

Frames with a wrong address byte, including one that differs only in the read/write bit, must leave the registers untouched. Traffic before the first chip-select fall must also have no effect, which catches a design that starts in serial mode.

// File: rtl/spi_ctl_port.sv
module spi_ctl_port #(
  parameter int NUM_REGS = 8,
  parameter int SYNC     = 2,
  parameter logic [6:0] CHIP_ID = 7'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_pin,
  input  logic       sck,
  input  logic       sdi,
  output logic       spi_mode,
  output logic       wr_en,
  output logic [6:0] wr_addr,
  output logic [7:0] wr_data
);
  localparam logic [7:0] ADDR_BYTE = {CHIP_ID, 1'b0};
  localparam logic [7:0] LIMIT = 8'(NUM_REGS);

  typedef enum logic [1:0] {P_ADDR, P_MAP, P_DATA, P_SKIP} phase_t;

  logic [SYNC-1:0] cs_q, sck_q, sdi_q;
  logic cs_d, sck_d;
  logic [2:0] bits;
  logic [7:0] shreg;
  logic [6:0] ptr;
  logic incr;
  phase_t phase;

  wire cs_s  = cs_q[SYNC-1];
  wire sck_s = sck_q[SYNC-1];
  wire sdi_s = sdi_q[SYNC-1];
  wire cs_fall  = cs_d & ~cs_s;
  wire sck_rise = sck_s & ~sck_d;
  wire [7:0] nxt = {shreg[6:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= '1; sck_q <= '0; sdi_q <= '0;
      cs_d <= 1'b1; sck_d <= 1'b0;
      spi_mode <= 1'b0;
    end else begin
      cs_q  <= {cs_q[SYNC-2:0], cs_pin};
      sck_q <= {sck_q[SYNC-2:0], sck};
      sdi_q <= {sdi_q[SYNC-2:0], sdi};
      cs_d  <= cs_s;
      sck_d <= sck_s;
      spi_mode <= spi_mode | cs_fall;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bits <= '0; shreg <= '0; ptr <= '0; incr <= 1'b0;
      phase <= P_ADDR;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (cs_s) begin
        bits  <= '0;
        phase <= P_ADDR;
      end else if (spi_mode && sck_rise) begin
        shreg <= nxt;
        bits  <= bits + 3'd1;
        if (bits == 3'd7)
          case (phase)
            P_ADDR: phase <= (nxt == ADDR_BYTE) ? P_MAP : P_SKIP;
            P_MAP: begin
              incr  <= nxt[7];
              ptr   <= nxt[6:0];
              phase <= P_DATA;
            end
            P_DATA: begin
              wr_en   <= ({1'b0, ptr} < LIMIT);
              wr_addr <= ptr;
              wr_data <= nxt;
              if (incr) ptr <= ptr + 7'd1;
            end
            default: ;
          endcase
      end
    end
endmodule

module spi_ctl_port_chk #(
  parameter int NUM_REGS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_mode,
  input logic       wr_en,
  input logic [6:0] wr_addr
);
  // R2
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> spi_mode);
  // R9
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NUM_REGS));
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R2
  no_write_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_mode |-> !wr_en);
  // R1
  always @(posedge clk)
    if (!rst_n) reset_idle_chk: assert (!wr_en && !spi_mode);
endmodule

bind spi_ctl_port spi_ctl_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/sim_spi_ctl_port.sv
module sim_spi_ctl_port;
  localparam int NREG = 8;
  localparam int HALF = 5;

  logic clk = 0, rst_n = 0, cs_pin = 1, sck = 0, sdi = 0;
  logic spi_mode, wr_en;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  int errors = 0, checks = 0;
  int got_wr = 0, exp_wr = 0;
  logic [7:0] got_rf [NREG];
  logic [7:0] exp_rf [NREG];
  logic [7:0] dbuf [8];
  bit done = 0;

  always #4 clk = ~clk;

  spi_ctl_port #(.NUM_REGS(NREG)) u0 (.*);

  always @(negedge clk)
    if (rst_n && wr_en) begin
      got_wr++;
      if (int'(wr_addr) < NREG) got_rf[wr_addr] = wr_data;
    end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdi = b[i]; idle(HALF);
      sck = 1;    idle(HALF);
      sck = 0;
    end
  endtask

  function automatic void model(input logic [7:0] a, input logic [7:0] m, input int n);
    int idx = int'(m[6:0]);
    if (a != 8'h20) return;
    for (int i = 0; i < n; i++) begin
      if (idx < NREG) begin
        exp_rf[idx] = dbuf[i];
        exp_wr++;
      end
      if (m[7]) idx = (idx + 1) % 128;
    end
  endfunction

  task automatic frame(input logic [7:0] a, input logic [7:0] m, input int n);
    model(a, m, n);
    cs_pin = 0; idle(4);
    send_bits(a, 8);
    send_bits(m, 8);
    for (int i = 0; i < n; i++) send_bits(dbuf[i], 8);
    idle(4); cs_pin = 1; idle(8);
  endtask

  task automatic check_rf(input string tag);
    int bad = 0;
    for (int i = 0; i < NREG; i++) if (got_rf[i] !== exp_rf[i]) bad++;
    chk({tag, " regfile mismatches"}, bad, 0);
    chk({tag, "/R10 write count"}, got_wr, exp_wr);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NREG; i++) begin got_rf[i] = 0; exp_rf[i] = 0; end
    idle(3); rst_n = 1; idle(2);
    chk("R1 spi_mode", spi_mode, 0);
    chk("R1 wr_en", wr_en, 0);

    // R2: traffic with cs high before first fall
    for (int i = 0; i < 24; i++) begin
      sdi = 1'($urandom); idle(HALF); sck = 1; idle(HALF); sck = 0;
    end
    idle(6);
    chk("R2 mode before fall", spi_mode, 0);
    chk("R2 no writes before fall", got_wr, 0);

    // R3: first frame, no increment
    dbuf[0] = 8'hA5;
    frame(8'h20, 8'h03, 1);
    chk("R2 mode latched", spi_mode, 1);
    chk("R3 reg3 msb-first", got_rf[3], 8'hA5);
    check_rf("R3");

    // R6: auto-advance
    dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
    frame(8'h20, 8'h85, 3);
    check_rf("R6");

    // R7: fixed index overwrite
    dbuf[0] = 8'h44; dbuf[1] = 8'h55; dbuf[2] = 8'h66;
    frame(8'h20, 8'h01, 3);
    chk("R7 last byte wins", got_rf[1], 8'h66);
    check_rf("R7");

    // R4: wrong chip address, including read bit
    dbuf[0] = 8'h77;
    frame(8'h21, 8'h00, 1);
    frame(8'h40, 8'h80, 1);
    check_rf("R4");

    // R8: abort in data byte
    cs_pin = 0; idle(4);
    send_bits(8'h20, 8); send_bits(8'h02, 8); send_bits(8'h99, 8);
    send_bits(8'hFF, 5);
    cs_pin = 1; idle(8);
    exp_rf[2] = 8'h99; exp_wr++;
    check_rf("R8 data abort");
    // R8: abort in address byte, then clean frame
    cs_pin = 0; idle(4); send_bits(8'h20, 4); cs_pin = 1; idle(8);
    dbuf[0] = 8'h12;
    frame(8'h20, 8'h00, 1);
    check_rf("R8 fresh frame");
    chk("R2 mode held", spi_mode, 1);

    // R9: out of range index and wrap
    dbuf[0] = 8'hBB;
    frame(8'h20, 8'h0A, 1);
    dbuf[0] = 8'hCC; dbuf[1] = 8'hDD;
    frame(8'h20, 8'hFF, 2);
    chk("R9 wrap to reg0", got_rf[0], 8'hDD);
    check_rf("R9/R5");

    // random frames
    for (int f = 0; f < 30; f++) begin
      logic [7:0] a, m;
      int n;
      a = ($urandom % 8 == 0) ? 8'($urandom) : 8'h20;
      m = {1'($urandom), 7'($urandom % 12)};
      n = 1 + int'($urandom % 5);
      for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
      frame(a, m, n);
      check_rf(a != 8'h20 ? "R4 random" : (m[7] ? "R6 random" : "R7 random"));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule